// File: doc/BRIEF.md
# Target-Cycle Unit Wrapper

This block sits around one leaf unit of a message-passing emulator and separates the host clock from the emulated (target) clock. Each input channel arrives as a link-width fragment stream. The wrapper puts the fragments back together into one message per target cycle, or takes an idle beat that advances time with no message. It gives the unit a one-cycle start pulse once every input has its token for the cycle and every output is free. It then waits for the unit's done. On done it commits the cycle. It frees the inputs, captures the unit's outputs and counts the cycle. Each captured output message is then split into fragments and sent on an outgoing link stream.

All fragment links use valid/ready. A beat moves on a rising clock edge when both valid and ready are high. An input link sees ready low while its channel already holds a token for the pending target cycle. An output link keeps valid, data and the idle flag unchanged until ready is seen. A message of `MSG_W` bits takes ceil(`MSG_W`/`FRAG_W`) fragments. The least significant fragment goes first. Padding bits above `MSG_W` in the last fragment are dropped on input and sent as zero on output.

Top module: `tcyc_wrapper`

## Requirements
- R1: While reset is low and in the first cycle after it, `unit_start` is 0, `target_cycle` is 0, every `in_frag_ready` bit is 1 and every `out_frag_valid` bit is 0.
- R2: An input message is the ceil(MSG_W/FRAG_W) accepted fragments, first fragment in bits [FRAG_W-1:0], next fragment above it, and so on. Once the last fragment is accepted, `unit_in_present` is 1 and `unit_in_data` holds the low MSG_W bits.
- R3: A beat with `in_frag_idle`=1 that lands on a message boundary is a whole idle token: the channel's token is complete with `unit_in_present`=0. On any other fragment position the idle flag is ignored and the beat is stored as data.
- R4: While a channel holds a complete token that is not yet committed, its `in_frag_ready` is 0 and further beats are not taken.
- R5: `unit_start` goes high for exactly one cycle. It rises on the clock edge after a cycle in which the wrapper was waiting, every input held a token and every output link was empty.
- R6: After a start, no further start is issued until done has been seen. A `unit_done` that arrives while no target cycle is running has no effect.
- R7: A `unit_done` during a running target cycle commits it on that clock edge. `target_cycle` (32 bits) increases by one, and every input token is released, so `in_frag_ready` returns to 1 on the next cycle.
- R8: At commit, each output channel with `unit_out_present`=1 sends ceil(MSG_W/FRAG_W) beats with `out_frag_idle`=0, least significant fragment first. An output channel with `unit_out_present`=0 sends one beat with `out_frag_idle`=1 and data 0.
- R9: While `out_frag_valid` is 1 and `out_frag_ready` is 0, valid, data and idle stay unchanged on the next cycle.
- R10: No start is issued while any output link still has beats left to send.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Host clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_frag_valid | input | N_IN | Per input link: fragment beat offered |
| in_frag_ready | output | N_IN | Per input link: wrapper can take a beat |
| in_frag_idle | input | N_IN | Per input link: beat is an idle token (honoured on first fragment only) |
| in_frag_data | input | N_IN*FRAG_W | Fragment payloads, link i at [i*FRAG_W +: FRAG_W] |
| out_frag_valid | output | N_OUT | Per output link: beat offered |
| out_frag_ready | input | N_OUT | Per output link: receiver takes the beat |
| out_frag_idle | output | N_OUT | Per output link: beat is an idle token |
| out_frag_data | output | N_OUT*FRAG_W | Outgoing fragment payloads |
| unit_start | output | 1 | One-cycle pulse that starts a target cycle in the unit |
| unit_done | input | 1 | Unit has finished the running target cycle |
| unit_in_data | output | N_IN*MSG_W | Reassembled input messages for the unit |
| unit_in_present | output | N_IN | Input channel holds a real message (not idle) |
| unit_out_data | input | N_OUT*MSG_W | Messages produced by the unit, sampled with done |
| unit_out_present | input | N_OUT | Unit produced a message on that output this cycle |
| target_cycle | output | 32 | Count of committed target cycles |

## Verification
The hardest case to reach from the ports is a start that is held back for a reason other than the inputs. All tokens are already present, but one output link is still draining the previous cycle under back-pressure. Done pulses also arrive while nothing is running. The stimulus throttles each output's ready on its own periodic pattern, mixes present and absent output messages, and varies the unit's done latency from zero to several cycles. A phase injects stray done pulses between cycles and places an idle flag on a middle fragment. A behavioural queue model predicts every output on every cycle.

// File: rtl/tcyc_pkg.sv
package tcyc_pkg;
  typedef enum logic {
    CTL_WAIT = 1'b0,
    CTL_RUN  = 1'b1
  } ctl_state_e;

  function automatic int frag_count(input int msg_w, input int frag_w);
    return (msg_w + frag_w - 1) / frag_w;
  endfunction
endpackage

// File: rtl/tcyc_unpack.sv
module tcyc_unpack #(
  parameter int MSG_W  = 20,
  parameter int FRAG_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frag_valid,
  output logic              frag_ready,
  input  logic              frag_idle,
  input  logic [FRAG_W-1:0] frag_data,
  input  logic              consume,
  output logic              tok_full,
  output logic              msg_present,
  output logic [MSG_W-1:0]  msg_data
);
  localparam int NFRAG = tcyc_pkg::frag_count(MSG_W, FRAG_W);
  localparam int PAD_W = NFRAG * FRAG_W;
  localparam int IDX_W = (NFRAG > 1) ? $clog2(NFRAG) : 1;
  localparam logic [IDX_W-1:0] LAST = IDX_W'(NFRAG - 1);

  logic [PAD_W-1:0] asm_q;
  logic [IDX_W-1:0] idx_q;
  logic             full_q;
  logic             pres_q;

  assign frag_ready  = !full_q;
  assign tok_full    = full_q;
  assign msg_present = full_q && pres_q;
  assign msg_data    = asm_q[MSG_W-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      asm_q  <= '0;
      idx_q  <= '0;
      full_q <= 1'b0;
      pres_q <= 1'b0;
    end else if (consume) begin
      full_q <= 1'b0;
    end else if (frag_valid && !full_q) begin
      if (frag_idle && idx_q == '0) begin
        full_q <= 1'b1;
        pres_q <= 1'b0;
      end else begin
        for (int k = 0; k < NFRAG; k++) begin
          if (idx_q == IDX_W'(k)) asm_q[k*FRAG_W +: FRAG_W] <= frag_data;
        end
        if (idx_q == LAST) begin
          full_q <= 1'b1;
          pres_q <= 1'b1;
          idx_q  <= '0;
        end else begin
          idx_q <= idx_q + 1'b1;
        end
      end
    end
  end

  // R4
  tok_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tok_full && !consume) |=> tok_full);

  // R7
  consume_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    consume |-> tok_full);
endmodule

// File: rtl/tcyc_pack.sv
module tcyc_pack #(
  parameter int MSG_W  = 20,
  parameter int FRAG_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              load_present,
  input  logic [MSG_W-1:0]  load_data,
  output logic              busy,
  output logic              frag_valid,
  input  logic              frag_ready,
  output logic              frag_idle,
  output logic [FRAG_W-1:0] frag_data
);
  localparam int NFRAG = tcyc_pkg::frag_count(MSG_W, FRAG_W);
  localparam int PAD_W = NFRAG * FRAG_W;
  localparam int IDX_W = (NFRAG > 1) ? $clog2(NFRAG) : 1;
  localparam logic [IDX_W-1:0] LAST = IDX_W'(NFRAG - 1);

  logic [PAD_W-1:0] hold_q;
  logic [IDX_W-1:0] idx_q;
  logic             busy_q;
  logic             has_q;

  assign busy       = busy_q;
  assign frag_valid = busy_q;
  assign frag_idle  = !has_q;

  always_comb begin
    frag_data = '0;
    for (int k = 0; k < NFRAG; k++) begin
      if (idx_q == IDX_W'(k)) frag_data = hold_q[k*FRAG_W +: FRAG_W];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hold_q <= '0;
      idx_q  <= '0;
      busy_q <= 1'b0;
      has_q  <= 1'b0;
    end else if (load) begin
      busy_q <= 1'b1;
      idx_q  <= '0;
      has_q  <= load_present;
      hold_q <= load_present ? PAD_W'(load_data) : '0;
    end else if (busy_q && frag_ready) begin
      if (!has_q || idx_q == LAST) begin
        busy_q <= 1'b0;
        idx_q  <= '0;
      end else begin
        idx_q <= idx_q + 1'b1;
      end
    end
  end

  // R9
  out_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (frag_valid && !frag_ready) |=> (frag_valid && $stable(frag_data) && $stable(frag_idle)));

  // R10
  load_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load |-> !busy_q);
endmodule

// File: rtl/tcyc_ctrl.sv
module tcyc_ctrl #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             all_in_full,
  input  logic             all_out_free,
  input  logic             done,
  output logic             start,
  output logic             commit,
  output logic [CNT_W-1:0] count
);
  import tcyc_pkg::*;

  ctl_state_e       state_q;
  logic             start_q;
  logic [CNT_W-1:0] count_q;

  assign start  = start_q;
  assign count  = count_q;
  assign commit = (state_q == CTL_RUN) && done;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= CTL_WAIT;
      start_q <= 1'b0;
      count_q <= '0;
    end else begin
      start_q <= 1'b0;
      case (state_q)
        CTL_WAIT: begin
          if (all_in_full && all_out_free) begin
            start_q <= 1'b1;
            state_q <= CTL_RUN;
          end
        end
        CTL_RUN: begin
          if (done) begin
            state_q <= CTL_WAIT;
            count_q <= count_q + 1'b1;
          end
        end
        default: state_q <= CTL_WAIT;
      endcase
    end
  end

  // R5
  start_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> !start);

  // R5
  start_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(start) |-> $past(all_in_full && all_out_free));

  // R7
  count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    commit |=> (count == $past(count) + 1'b1));

  // R6
  count_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !commit |=> $stable(count));
endmodule

// File: rtl/tcyc_wrapper.sv
module tcyc_wrapper #(
  parameter int N_IN   = 2,
  parameter int N_OUT  = 2,
  parameter int MSG_W  = 20,
  parameter int FRAG_W = 8,
  parameter int CNT_W  = 32
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [N_IN-1:0]         in_frag_valid,
  output logic [N_IN-1:0]         in_frag_ready,
  input  logic [N_IN-1:0]         in_frag_idle,
  input  logic [N_IN*FRAG_W-1:0]  in_frag_data,
  output logic [N_OUT-1:0]        out_frag_valid,
  input  logic [N_OUT-1:0]        out_frag_ready,
  output logic [N_OUT-1:0]        out_frag_idle,
  output logic [N_OUT*FRAG_W-1:0] out_frag_data,
  output logic                    unit_start,
  input  logic                    unit_done,
  output logic [N_IN*MSG_W-1:0]   unit_in_data,
  output logic [N_IN-1:0]         unit_in_present,
  input  logic [N_OUT*MSG_W-1:0]  unit_out_data,
  input  logic [N_OUT-1:0]        unit_out_present,
  output logic [CNT_W-1:0]        target_cycle
);
  logic [N_IN-1:0]  in_full;
  logic [N_OUT-1:0] out_busy;
  logic             commit;

  for (genvar i = 0; i < N_IN; i++) begin : g_in
    tcyc_unpack #(.MSG_W(MSG_W), .FRAG_W(FRAG_W)) u_unpack (
      .clk         (clk),
      .rst_n       (rst_n),
      .frag_valid  (in_frag_valid[i]),
      .frag_ready  (in_frag_ready[i]),
      .frag_idle   (in_frag_idle[i]),
      .frag_data   (in_frag_data[i*FRAG_W +: FRAG_W]),
      .consume     (commit),
      .tok_full    (in_full[i]),
      .msg_present (unit_in_present[i]),
      .msg_data    (unit_in_data[i*MSG_W +: MSG_W])
    );
  end

  for (genvar o = 0; o < N_OUT; o++) begin : g_out
    tcyc_pack #(.MSG_W(MSG_W), .FRAG_W(FRAG_W)) u_pack (
      .clk          (clk),
      .rst_n        (rst_n),
      .load         (commit),
      .load_present (unit_out_present[o]),
      .load_data    (unit_out_data[o*MSG_W +: MSG_W]),
      .busy         (out_busy[o]),
      .frag_valid   (out_frag_valid[o]),
      .frag_ready   (out_frag_ready[o]),
      .frag_idle    (out_frag_idle[o]),
      .frag_data    (out_frag_data[o*FRAG_W +: FRAG_W])
    );
  end

  tcyc_ctrl #(.CNT_W(CNT_W)) u_ctrl (
    .clk          (clk),
    .rst_n        (rst_n),
    .all_in_full  (&in_full),
    .all_out_free (~|out_busy),
    .done         (unit_done),
    .start        (unit_start),
    .commit       (commit),
    .count        (target_cycle)
  );

  // R10
  start_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(unit_start) |-> !$past(|out_valid_or_busy()));

  function automatic logic [N_OUT-1:0] out_valid_or_busy();
    return out_frag_valid;
  endfunction

  // R4
  ready_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_frag_ready && !commit) |=> !in_frag_ready);
endmodule

// File: tb/tcyc_wrapper_tb.sv
module tcyc_wrapper_tb;
  localparam int NI = 2;
  localparam int NO = 2;
  localparam int MW = 20;
  localparam int FW = 8;
  localparam int NF = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic [NI-1:0]    in_frag_valid = '0;
  logic [NI-1:0]    in_frag_ready;
  logic [NI-1:0]    in_frag_idle = '0;
  logic [NI*FW-1:0] in_frag_data = '0;
  logic [NO-1:0]    out_frag_valid;
  logic [NO-1:0]    out_frag_ready = '1;
  logic [NO-1:0]    out_frag_idle;
  logic [NO*FW-1:0] out_frag_data;
  logic             unit_start;
  logic             unit_done = 1'b0;
  logic [NI*MW-1:0] unit_in_data;
  logic [NI-1:0]    unit_in_present;
  logic [NO*MW-1:0] unit_out_data = '0;
  logic [NO-1:0]    unit_out_present = '0;
  logic [31:0]      target_cycle;

  tcyc_wrapper #(.N_IN(NI), .N_OUT(NO), .MSG_W(MW), .FRAG_W(FW), .CNT_W(32)) u_dut (
    .clk(clk), .rst_n(rst_n),
    .in_frag_valid(in_frag_valid), .in_frag_ready(in_frag_ready),
    .in_frag_idle(in_frag_idle), .in_frag_data(in_frag_data),
    .out_frag_valid(out_frag_valid), .out_frag_ready(out_frag_ready),
    .out_frag_idle(out_frag_idle), .out_frag_data(out_frag_data),
    .unit_start(unit_start), .unit_done(unit_done),
    .unit_in_data(unit_in_data), .unit_in_present(unit_in_present),
    .unit_out_data(unit_out_data), .unit_out_present(unit_out_present),
    .target_cycle(target_cycle)
  );

  int n_checks = 0;
  int n_fail = 0;

  // stimulus state
  logic [8:0] iq [NI][$];
  int  cyc = 0;
  bit  gap_en = 0, thr_en = 0, stray_en = 0, mix_pres = 0;
  int  lat = 1;
  bit  u_pend = 0;
  int  u_delay = 0;
  int  u_cnt = 0;

  // reference model state
  bit          m_have [NI];
  bit          m_pres [NI];
  logic [23:0] m_acc [NI];
  int          m_idx [NI];
  bit          m_run = 0, m_start = 0;
  logic [31:0] m_tc = 0;
  logic [8:0]  oq [NO][$];

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // reference model: compare at negedge, then advance to the next edge
  initial begin
    forever begin
      @(negedge clk);
      if (!rst_n) begin
        for (int i = 0; i < NI; i++) begin
          m_have[i] = 0; m_pres[i] = 0; m_idx[i] = 0; m_acc[i] = '0;
        end
        for (int o = 0; o < NO; o++) oq[o].delete();
        m_run = 0; m_start = 0; m_tc = 0;
      end else begin
        bit all_ready, commit;
        chk(unit_start == m_start, "R5/R6/R10", "unit_start", unit_start, m_start);
        chk(target_cycle == m_tc, "R7", "target_cycle", target_cycle, m_tc);
        for (int i = 0; i < NI; i++) begin
          chk(in_frag_ready[i] == !m_have[i], "R4", "in_frag_ready", in_frag_ready[i], !m_have[i]);
          chk(unit_in_present[i] == (m_have[i] && m_pres[i]), "R3", "unit_in_present",
              unit_in_present[i], m_have[i] && m_pres[i]);
          if (m_have[i] && m_pres[i])
            chk(unit_in_data[i*MW +: MW] == m_acc[i][MW-1:0], "R2", "unit_in_data",
                unit_in_data[i*MW +: MW], m_acc[i][MW-1:0]);
        end
        for (int o = 0; o < NO; o++) begin
          chk(out_frag_valid[o] == (oq[o].size() > 0), "R9", "out_frag_valid",
              out_frag_valid[o], oq[o].size() > 0);
          if (oq[o].size() > 0)
            chk({out_frag_idle[o], out_frag_data[o*FW +: FW]} == oq[o][0], "R8", "out beat",
                {out_frag_idle[o], out_frag_data[o*FW +: FW]}, oq[o][0]);
        end
        // next-state
        all_ready = 1;
        for (int i = 0; i < NI; i++) if (!m_have[i]) all_ready = 0;
        for (int o = 0; o < NO; o++) if (oq[o].size() > 0) all_ready = 0;
        commit = m_run && unit_done;
        for (int o = 0; o < NO; o++)
          if (oq[o].size() > 0 && out_frag_ready[o]) void'(oq[o].pop_front());
        for (int i = 0; i < NI; i++) begin
          if (in_frag_valid[i] && !m_have[i]) begin
            if (in_frag_idle[i] && m_idx[i] == 0) begin
              m_have[i] = 1; m_pres[i] = 0;
            end else begin
              m_acc[i][m_idx[i]*FW +: FW] = in_frag_data[i*FW +: FW];
              if (m_idx[i] == NF-1) begin
                m_have[i] = 1; m_pres[i] = 1; m_idx[i] = 0;
              end else m_idx[i]++;
            end
          end
        end
        m_start = 0;
        if (!m_run && all_ready) begin
          m_start = 1; m_run = 1;
        end else if (commit) begin
          m_run = 0;
          m_tc++;
          for (int i = 0; i < NI; i++) m_have[i] = 0;
          for (int o = 0; o < NO; o++) begin
            if (unit_out_present[o]) begin
              logic [23:0] d;
              d = 24'(unit_out_data[o*MW +: MW]);
              for (int k = 0; k < NF; k++) oq[o].push_back({1'b0, d[k*FW +: FW]});
            end else oq[o].push_back(9'h100);
          end
        end
      end
    end
  end

  // one host cycle of all stimulus drivers
  task automatic tick();
    bit hs [NI];
    @(negedge clk);
    for (int i = 0; i < NI; i++) hs[i] = in_frag_valid[i] && in_frag_ready[i];
    @(posedge clk);
    #1;
    cyc++;
    for (int i = 0; i < NI; i++) begin
      if (hs[i]) void'(iq[i].pop_front());
      if (iq[i].size() == 0) in_frag_valid[i] = 0;
      else if (!(gap_en && i == 1 && !in_frag_valid[i] && (cyc % 4 == 1))) begin
        in_frag_valid[i] = 1;
        in_frag_idle[i] = iq[i][0][8];
        in_frag_data[i*FW +: FW] = iq[i][0][7:0];
      end
    end
    out_frag_ready[0] = thr_en ? (cyc % 3 == 0) : 1'b1;
    out_frag_ready[1] = thr_en ? (cyc % 5 < 2) : 1'b1;
    unit_done = 0;
    if (unit_start) begin
      u_pend = 1; u_delay = lat;
    end
    if (u_pend) begin
      if (u_delay == 0) begin
        unit_done = 1; u_pend = 0;
        u_cnt++;
        unit_out_data = {MW'(u_cnt * 7 + 3), MW'(u_cnt * 13 + 1)};
        unit_out_present = mix_pres ? {u_cnt[0], ~u_cnt[1]} : 2'b11;
      end else u_delay--;
    end else if (stray_en && !unit_start && (cyc % 3 == 0)) unit_done = 1;
  endtask

  task automatic put_msg(input int ch, input logic [MW-1:0] d, input bit mid_idle);
    logic [23:0] p;
    p = 24'(d);
    p[23:20] = 4'hA; // padding bits must be dropped (R2)
    for (int k = 0; k < NF; k++) iq[ch].push_back({(mid_idle && k == 1), p[k*FW +: FW]});
  endtask

  task automatic put_idle(input int ch);
    iq[ch].push_back(9'h1C3); // idle beat with junk data (R3)
  endtask

  task automatic drain();
    for (int n = 0; n < 3000; n++) begin
      bit busy;
      tick();
      busy = m_run;
      for (int i = 0; i < NI; i++) if (iq[i].size() > 0 || m_have[i]) busy = 1;
      for (int o = 0; o < NO; o++) if (oq[o].size() > 0) busy = 1;
      if (!busy) break;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] tc_before;
    repeat (3) tick();
    // R1: reset values, sampled while reset is still low
    n_checks++;
    if (unit_start !== 1'b0 || target_cycle !== 32'd0 || in_frag_ready !== '1 || out_frag_valid !== '0) begin
      n_fail++;
      $display("FAIL R1 reset state: start=%0b tc=%0h rdy=%0b ov=%0b expected 0 0 11 00",
               unit_start, target_cycle, in_frag_ready, out_frag_valid);
    end
    rst_n = 1;
    tick();
    // Phase A (R2 R5 R7 R8): plain messages, channel 1 with gaps
    gap_en = 1; lat = 1;
    for (int k = 0; k < 4; k++) begin
      put_msg(0, MW'(20'h12345 + k * 20'h1111), 0);
      put_msg(1, MW'(20'hF0E0D - k * 20'h0321), 0);
    end
    drain();
    n_checks++;
    if (target_cycle != 32'd4) begin
      n_fail++; $display("FAIL R7 cycles after phase A: actual=%0d expected=4", target_cycle);
    end
    // Phase B (R3): idle tokens and an idle flag on a middle fragment
    lat = 0;
    put_idle(0); put_msg(1, 20'hABCDE, 1);
    put_msg(0, 20'h00F0F, 1); put_idle(1);
    put_idle(0); put_idle(1);
    drain();
    // Phase C (R9 R10): output back-pressure, mixed present, varied latency
    thr_en = 1; mix_pres = 1;
    for (int k = 0; k < 6; k++) begin
      lat = (k % 2 == 0) ? 0 : 3;
      put_msg(0, MW'(k * 20'h0BEEF), 0);
      if (k % 3 == 1) put_idle(1); else put_msg(1, MW'(20'h55555 ^ k), 0);
      drain();
    end
    // Phase D (R6): stray done pulses between target cycles
    thr_en = 0; stray_en = 1; lat = 4;
    tc_before = target_cycle;
    for (int k = 0; k < 3; k++) begin
      put_msg(0, MW'(20'h31415 + k), 0);
      put_msg(1, MW'(20'h27182 + k), 0);
    end
    drain();
    repeat (10) tick();
    n_checks++;
    if (target_cycle != tc_before + 3) begin
      n_fail++;
      $display("FAIL R6 stray done changed count: actual=%0d expected=%0d", target_cycle, tc_before + 3);
    end
    stray_en = 0;
    repeat (4) tick();
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end
endmodule